// File: doc/BRIEF.md
# Floating-Point Control and Status Register

This block holds the control and status word that sits beside a floating-point datapath. Software loads it through a single-cycle write port and can always read the whole word back. The rounding-mode field is decoded and presented to the arithmetic units, both as the raw two-bit code and as a one-hot select.

Each cycle a completing operation may present a five-bit vector of IEEE exception conditions. Every condition is ORed into its own sticky status bit, and the bit stays set until software overwrites the word. When a nonzero condition vector is accumulated while the exception-enable bit is set, the block issues a one-cycle trap request.

Top module: `fpu_ctrl_status`

## Requirements
- R1: On a write (`wr_en`=1), the word read back from the next cycle on equals the low 12 bits of `wr_data`, and bits [31:12] of `rd_data` always read as zero.
- R2: `rnd_mode` equals `rd_data[2:1]`. `rnd_sel` is one-hot, with bit k set for code k: 0 nearest-even, 1 toward zero, 2 toward +infinity, 3 toward -infinity.
- R3: Each input flag `exc_flags` bit sets its own status bit: [0] invalid sets bit 9, [1] overflow sets bit 3, [2] underflow sets bit 4, [3] divide-by-zero sets bit 7, [4] inexact sets bit 8.
- R4: Status bits are sticky. Incoming flags are ORed in, and without a write no bit of the word ever goes from 1 to 0.
- R5: If `exc_flags` is nonzero, enable bit 0 of the current word is 1 and no write occurs, then `trap_req` is high for exactly the next cycle. In every other case `trap_req` is low.
- R6: When `exc_flags` is zero and no write occurs, the word is unchanged in the next cycle and `trap_req` is low.
- R7: When a write and nonzero flags arrive in the same cycle, the written value is stored, the flags are discarded and no trap is requested.
- R8: A synchronous active-high `rst` clears the word to zero, which selects nearest-even rounding with traps disabled, and holds `trap_req` low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Software write strobe |
| wr_data | input | 32 | Software write value |
| exc_flags | input | 5 | Exception conditions from a completing operation |
| rd_data | output | 32 | Current register word |
| rnd_mode | output | 2 | Rounding-mode code |
| rnd_sel | output | 4 | One-hot rounding-mode select |
| trap_req | output | 1 | One-cycle trap request |

## Verification
The hardest case is the collision, where a write and nonzero flags arrive in the same cycle while traps are enabled. Without the right priority, the flags leak into the stored word or a trap appears. Reaching it requires first writing the enable bit, so the random stream writes often, with values whose bit 0 is random. Flags are nonzero in half of the cycles, so collisions arise in both enable states. Directed steps also force the collision and repeated flag bursts while the enable bit is set.

// File: rtl/fpu_csr_pkg.sv
package fpu_csr_pkg;
    localparam int DATA_W  = 32;
    localparam int CSR_W   = 12;
    localparam int NFLAG   = 5;
    localparam int RM_W    = 2;
    localparam int NRM     = 1 << RM_W;
    localparam int EN_BIT  = 0;
    localparam int RM_LSB  = 1;

    // Status bit position for each incoming flag: invalid, overflow, underflow, div0, inexact
    function automatic int flag_pos(input int idx);
        case (idx)
            0:       return 9;
            1:       return 3;
            2:       return 4;
            3:       return 7;
            default: return 8;
        endcase
    endfunction

    typedef struct packed {
        logic [CSR_W-1:0] csr;
        logic             trap;
    } csr_state_t;
endpackage

// File: rtl/fpu_csr_flag_map.sv
module fpu_csr_flag_map
    import fpu_csr_pkg::*;
(
    input  logic [NFLAG-1:0] flags,
    output logic [CSR_W-1:0] status_bits
);
    logic [NFLAG-1:0][CSR_W-1:0] part;

    for (genvar g = 0; g < NFLAG; g++) begin : g_map
        assign part[g] = flags[g] ? (CSR_W'(1) << flag_pos(g)) : '0;
    end

    always_comb begin
        status_bits = '0;
        for (int i = 0; i < NFLAG; i++) begin
            status_bits = status_bits | part[i];
        end
    end
endmodule

// File: rtl/fpu_csr_round_dec.sv
module fpu_csr_round_dec
    import fpu_csr_pkg::*;
(
    input  logic [RM_W-1:0] mode,
    output logic [NRM-1:0]  sel
);
    for (genvar k = 0; k < NRM; k++) begin : g_sel
        assign sel[k] = (mode == RM_W'(k));
    end
endmodule

// File: rtl/fpu_ctrl_status.sv
module fpu_ctrl_status
    import fpu_csr_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [NFLAG-1:0]  exc_flags,
    output logic [DATA_W-1:0] rd_data,
    output logic [RM_W-1:0]   rnd_mode,
    output logic [NRM-1:0]    rnd_sel,
    output logic              trap_req
);
    csr_state_t       st_d, st_q;
    logic [CSR_W-1:0] new_bits;

    fpu_csr_flag_map u_map (
        .flags       (exc_flags),
        .status_bits (new_bits)
    );

    always_comb begin
        st_d      = st_q;
        st_d.trap = 1'b0;
        if (wr_en) begin
            st_d.csr = wr_data[CSR_W-1:0];
        end else if (exc_flags != '0) begin
            st_d.csr  = st_q.csr | new_bits;
            st_d.trap = st_q.csr[EN_BIT];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rd_data  = {{(DATA_W-CSR_W){1'b0}}, st_q.csr};
    assign rnd_mode = st_q.csr[RM_LSB +: RM_W];
    assign trap_req = st_q.trap;

    fpu_csr_round_dec u_rdec (
        .mode (rnd_mode),
        .sel  (rnd_sel)
    );

    p_write_mask_r1: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> rd_data == {{(DATA_W-CSR_W){1'b0}}, $past(wr_data[CSR_W-1:0])});

    p_sel_onehot_r2: assert property (@(posedge clk) disable iff (rst)
        $countones(rnd_sel) == 1 && rnd_sel[rd_data[2:1]]);

    p_sticky_r4: assert property (@(posedge clk) disable iff (rst)
        !wr_en |=> (rd_data & $past(rd_data)) == $past(rd_data));

    p_trap_cause_r5: assert property (@(posedge clk) disable iff (rst)
        (!wr_en && exc_flags != '0 && rd_data[EN_BIT]) |=> trap_req);

    p_trap_pulse_r5: assert property (@(posedge clk) disable iff (rst)
        trap_req |=> !trap_req || $past(exc_flags != '0));

    p_idle_r6: assert property (@(posedge clk) disable iff (rst)
        (!wr_en && exc_flags == '0) |=> $stable(rd_data) && !trap_req);

    p_write_wins_r7: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> !trap_req);
endmodule

// File: tb/fpu_ctrl_status_tb_top.sv
module fpu_ctrl_status_tb_top;
    logic        clk = 1'b0;
    logic        rst;
    logic        wr_en;
    logic [31:0] wr_data;
    logic [4:0]  exc_flags;
    logic [31:0] rd_data;
    logic [1:0]  rnd_mode;
    logic [3:0]  rnd_sel;
    logic        trap_req;

    int checks = 0;
    int errors = 0;
    logic [11:0] exp_csr;
    logic        exp_trap;
    logic        done = 1'b0;

    always #2 clk = ~clk;

    fpu_ctrl_status dut_i (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data),
        .exc_flags(exc_flags), .rd_data(rd_data), .rnd_mode(rnd_mode),
        .rnd_sel(rnd_sel), .trap_req(trap_req)
    );

    function automatic logic [11:0] map_flags(input logic [4:0] f);
        logic [11:0] m = '0;
        m[9] = f[0];
        m[3] = f[1];
        m[4] = f[2];
        m[7] = f[3];
        m[8] = f[4];
        return m;
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic check_all(input string tag);
        chk({tag, " R1 rd_data"}, rd_data, {20'b0, exp_csr});
        chk("R2 rnd_mode", {30'b0, rnd_mode}, {30'b0, exp_csr[2:1]});
        chk("R2 rnd_sel", {28'b0, rnd_sel}, 32'(4'b0001 << exp_csr[2:1]));
        chk({tag, " R5 trap_req"}, {31'b0, trap_req}, {31'b0, exp_trap});
    endtask

    // apply one cycle of stimulus at a negedge, update the model, check at the next negedge
    task automatic step(input logic we, input logic [31:0] wd, input logic [4:0] f, input string tag);
        wr_en = we; wr_data = wd; exc_flags = f;
        exp_trap = 1'b0;
        if (we) begin
            exp_csr = wd[11:0];
        end else if (f != 0) begin
            exp_trap = exp_csr[0];
            exp_csr  = exp_csr | map_flags(f);
        end
        @(negedge clk);
        check_all(tag);
    endtask

    initial begin
        process::self().srandom(32'd20240611);
        rst = 1'b1; wr_en = 1'b0; wr_data = '0; exc_flags = '0;
        repeat (3) @(negedge clk);
        exp_csr = '0; exp_trap = 1'b0;
        check_all("R8 reset");
        rst = 1'b0;

        step(1'b1, 32'hFFFF_FFFF, 5'd0, "R1 mask");
        step(1'b1, 32'h0000_0000, 5'd0, "R1 clear");
        step(1'b0, 32'h0, 5'b00001, "R3 invalid");
        step(1'b0, 32'h0, 5'b00010, "R3 overflow");
        step(1'b0, 32'h0, 5'b00100, "R3 underflow");
        step(1'b0, 32'h0, 5'b01000, "R3 div0");
        step(1'b0, 32'h0, 5'b10000, "R3 inexact");
        step(1'b0, 32'h0, 5'b00000, "R6 idle");
        chk("R4 sticky all", rd_data, 32'h0000_0398);
        for (int m = 0; m < 4; m++) begin
            step(1'b1, 32'(m << 1), 5'd0, "R2 mode");
            chk("R2 code", {30'b0, rnd_mode}, 32'(m));
        end
        step(1'b1, 32'h0000_0001, 5'd0, "R5 enable");
        step(1'b0, 32'h0, 5'b00010, "R5 trap");
        chk("R5 trap pulse high", {31'b0, trap_req}, 32'd1);
        step(1'b0, 32'h0, 5'b00000, "R5 pulse ends");
        chk("R5 trap pulse low", {31'b0, trap_req}, 32'd0);
        step(1'b0, 32'h0, 5'b00010, "R5 repeat trap");
        step(1'b1, 32'h0000_0005, 5'b11111, "R7 collision");
        chk("R7 word", rd_data, 32'h5);
        step(1'b0, 32'h0, 5'b00000, "R6 after collision");
        step(1'b0, 32'h0, 5'b11111, "R5 enabled all");
        step(1'b0, 32'h0, 5'b00000, "R6 idle");
        step(1'b1, 32'h0, 5'd0, "R1 zero");

        for (int i = 0; i < 3000; i++) begin
            logic we = ($urandom_range(0, 7) == 0);
            logic [31:0] wd = $urandom();
            logic [4:0] f = ($urandom_range(0, 1) == 0) ? 5'd0 : 5'($urandom());
            step(we, wd, f, "R4 random");
        end

        rst = 1'b1;
        @(negedge clk);
        exp_csr = '0; exp_trap = 1'b0;
        check_all("R8 late reset");
        rst = 1'b0;
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule